// File: doc/BRIEF.md
# Interrupt Status Register Bank

This block keeps the interrupt state of a serial bus controller behind a small word-addressed register port. Internal event pulses raise bits in a stored status word. Software clears a window of those bits by writing ones, or overwrites the whole word through a write-only force location. Two enable words shape what software sees and what reaches the interrupt pin. The status-enable word masks reads of the status. The signal-enable word masks the raw status before it drives one level-sensitive interrupt output.

Register accesses arrive as one request per cycle, qualified by `req_valid`. The bank accepts every request, so the port has no back-pressure and no ready signal. A read returns its data one cycle later with `rsp_valid` high for that one cycle, and the receiver must take it then. A write produces no response. The word index is the byte offset shifted right by two. The bank decodes these word indices: status 0, status-enable 1, signal-enable 2, force 3, reset-control 4, command port 5.

Top module: `irq_regbank`

## Requirements
- R1: A synchronous active-high `rst` clears the status, status-enable and signal-enable words and drives `irq_o` low. `rsp_valid` is also low while reset is held.
- R2: A read of word 0 returns the stored status ANDed bitwise with the status-enable word.
- R3: `irq_o` is a registered output. After each clock edge it equals the OR of all bits of (signal-enable AND raw status), using the values those registers held before that edge.
- R4: A write to word 0 clears each status bit in positions 13 down to 5 whose written bit is 1. Status bits outside 13:5 and bits written as 0 keep their value.
- R5: A write to word 3 (force) replaces the whole stored status with the written value. Events in the same cycle still set their bits.
- R6: Words 3, 4, 5 and every undecoded index read as zero. Writes to words 4, 5 and to undecoded indices change no stored state.
- R7: Writes to word 1 or word 2 store all 32 bits, and a later read of the same word returns them.
- R8: A high bit on `evt_set` sets the matching status bit at the next edge. When an event and a software clear or force hit the same bit in one cycle, the bit ends set.
- R9: A read request sampled at an edge gives `rsp_valid` high after that edge for exactly one cycle. The data reflects the register state before that edge. A write request gives `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word index (byte offset divided by four) |
| req_wdata | input | 32 | Write data |
| evt_set | input | 32 | Event pulses, one per status bit |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt output |

## Verification
Read data and `rsp_valid` are due in the cycle after the request edge and hold the pre-edge register values. `irq_o` after an edge reflects the stored words as they stood before that edge, so it trails any register change by one cycle. The bench drives each request on a falling edge and samples on the next falling edge. It compares against a model state that it updates only after sampling, so every expected value keeps to these one-cycle offsets.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam logic [DATA_W-1:0] CLR_WINDOW = 32'h0000_3FE0;

  localparam logic [ADDR_W-1:0] IDX_STATUS  = 4'd0;
  localparam logic [ADDR_W-1:0] IDX_STAT_EN = 4'd1;
  localparam logic [ADDR_W-1:0] IDX_SIG_EN  = 4'd2;
  localparam logic [ADDR_W-1:0] IDX_FORCE   = 4'd3;
  localparam logic [ADDR_W-1:0] IDX_RSTCTL  = 4'd4;
  localparam logic [ADDR_W-1:0] IDX_CMDPORT = 4'd5;

  typedef struct packed {
    logic clr_we;
    logic force_we;
    logic stat_en_we;
    logic sig_en_we;
    logic rd;
  } dec_t;
endpackage

// File: rtl/irqbank_status.sv
module irqbank_status #(
  parameter int W = 32,
  parameter logic [W-1:0] CLR_MASK = 32'h0000_3FE0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_set,
  input  logic         clr_we,
  input  logic         force_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status_q
);
  logic [W-1:0] base;

  // one bit slice per status position: force beats clear, event beats both
  always_comb begin
    base = status_q;
    if (force_we)    base = wdata;
    else if (clr_we) base = status_q & ~(wdata & CLR_MASK);
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) status_q[i] <= 1'b0;
        else     status_q[i] <= base[i] | evt_set[i];
      end
    end
  endgenerate
endmodule

// File: rtl/irqbank_enable.sv
module irqbank_enable #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/irqbank_readout.sv
module irqbank_readout #(
  parameter int W = 32,
  parameter int A = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd,
  input  logic [A-1:0] addr,
  input  logic [W-1:0] status_q,
  input  logic [W-1:0] stat_en_q,
  input  logic [W-1:0] sig_en_q,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_rdata
);
  import irqbank_pkg::*;
  logic [W-1:0] sel;

  always_comb begin
    case (addr)
      IDX_STATUS:  sel = status_q & stat_en_q;
      IDX_STAT_EN: sel = stat_en_q;
      IDX_SIG_EN:  sel = sig_en_q;
      default:     sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? sel : '0;
    end
  end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irqbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] evt_set,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_o
);
  dec_t dec;
  logic [DATA_W-1:0] status_q, stat_en_q, sig_en_q;

  always_comb begin
    dec = '0;
    dec.rd = req_valid & ~req_write;
    if (req_valid & req_write) begin
      dec.clr_we     = (req_addr == IDX_STATUS);
      dec.stat_en_we = (req_addr == IDX_STAT_EN);
      dec.sig_en_we  = (req_addr == IDX_SIG_EN);
      dec.force_we   = (req_addr == IDX_FORCE);
    end
  end

  irqbank_status #(.W(DATA_W), .CLR_MASK(CLR_WINDOW)) u_status (
    .clk(clk), .rst(rst), .evt_set(evt_set), .clr_we(dec.clr_we),
    .force_we(dec.force_we), .wdata(req_wdata), .status_q(status_q)
  );

  irqbank_enable #(.W(DATA_W)) u_stat_en (
    .clk(clk), .rst(rst), .we(dec.stat_en_we), .wdata(req_wdata), .q(stat_en_q)
  );

  irqbank_enable #(.W(DATA_W)) u_sig_en (
    .clk(clk), .rst(rst), .we(dec.sig_en_we), .wdata(req_wdata), .q(sig_en_q)
  );

  irqbank_readout #(.W(DATA_W), .A(ADDR_W)) u_read (
    .clk(clk), .rst(rst), .rd(dec.rd), .addr(req_addr),
    .status_q(status_q), .stat_en_q(stat_en_q), .sig_en_q(sig_en_q),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(sig_en_q & status_q);
  end
endmodule

// File: rtl/irqbank_chk.sv
module irqbank_chk
  import irqbank_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] evt_set,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              irq_o,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] stat_en_q
);
  // R1: leaving reset, the line is low
  a_r1_irq_low_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !irq_o);

  // R9: read request yields one response beat
  a_r9_read_resp: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  a_r9_write_no_resp: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !rsp_valid);

  // R6: force location reads zero
  a_r6_force_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr == IDX_FORCE) |=> rsp_rdata == '0);

  // R2: status read carries no bit outside status-enable
  a_r2_masked_read: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr == IDX_STATUS)
      |=> (rsp_rdata & ~$past(stat_en_q)) == '0);

  // R4: a status write never drops a bit outside 13:5
  a_r4_outside_window_kept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == IDX_STATUS)
      |=> ($past(status_q) & ~CLR_WINDOW & ~status_q) == '0);

  // R8: every pulsed event bit is set afterwards
  a_r8_event_sets: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ($past(evt_set) & ~status_q) == '0);
endmodule

bind irq_regbank irqbank_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .evt_set(evt_set), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .irq_o(irq_o), .status_q(status_q),
  .stat_en_q(stat_en_q)
);

// File: tb/sim_irq_regbank.sv
`timescale 1ns/100ps
module sim_irq_regbank;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata, evt_set;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] m_st, m_se, m_sg;

  always #2.5 clk = ~clk;

  irq_regbank u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .evt_set(evt_set),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return m_st & m_se;
      4'd1: return m_se;
      4'd2: return m_sg;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] next_status(input logic v, input logic w,
      input logic [3:0] a, input logic [31:0] d, input logic [31:0] e);
    logic [31:0] s;
    s = m_st;
    if (v && w && a == 4'd3) s = d;
    else if (v && w && a == 4'd0) s = m_st & ~(d & 32'h0000_3FE0);
    return s | e;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request per cycle; starts and ends just after a falling edge
  task automatic op(input logic v, input logic w, input logic [3:0] a,
                    input logic [31:0] d, input logic [31:0] e);
    logic        e_irq;
    logic [31:0] e_rd;
    e_irq = |(m_sg & m_st);
    e_rd  = exp_read(a);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; evt_set = e;
    @(negedge clk);
    check("R3 irq", {31'b0, irq_o}, {31'b0, e_irq});
    check("R9 rsp_valid", {31'b0, rsp_valid}, {31'b0, v && !w});
    if (v && !w) begin
      if (a == 4'd0)      check("R2 status read", rsp_rdata, e_rd);
      else if (a <= 4'd2) check("R7 enable read", rsp_rdata, e_rd);
      else                check("R6 zero read", rsp_rdata, e_rd);
    end
    m_st = next_status(v, w, a, d, e);
    if (v && w && a == 4'd1) m_se = d;
    if (v && w && a == 4'd2) m_sg = d;
    req_valid = 0; req_write = 0; evt_set = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    op(1, 0, a, 32'h0, 32'h0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    op(1, 1, a, d, 32'h0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; evt_set = 0;
    m_st = 0; m_se = 0; m_sg = 0;
    repeat (3) @(negedge clk);
    evt_set = 32'hFFFF_FFFF;
    @(negedge clk);
    evt_set = 0;
    rst = 0;
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    // R1: stored words read back as zero
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd0);
    rd(4'd2);

    // R8/R4: bit 0 outside window survives a clear; bit 5 inside is cleared
    op(0, 0, 4'd0, 32'h0, 32'h0000_0021);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0);
    check("R4 bit0 kept bit5 cleared", m_st, 32'h0000_0001);
    // R8: collision on bit 6, set wins
    op(0, 0, 4'd0, 32'h0, 32'h0000_0040);
    op(1, 1, 4'd0, 32'h0000_0040, 32'h0000_0040);
    rd(4'd0);
    // R5: force replaces the whole word
    wr(4'd3, 32'hA5A5_0000);
    rd(4'd0);
    rd(4'd3);
    // R6: writes to reset-control, command port, undecoded index change nothing
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd0); rd(4'd1); rd(4'd2); rd(4'd4); rd(4'd5); rd(4'd9);
    // R3: signal enable drives the line from raw status despite read mask
    wr(4'd1, 32'h0);
    wr(4'd2, 32'h8000_0000);
    op(0, 0, 4'd0, 32'h0, 32'h0);
    op(0, 0, 4'd0, 32'h0, 32'h0);
    check("R3 irq high on raw status", {31'b0, irq_o}, 32'h1);
    rd(4'd0);
    // R7: full-width storage
    wr(4'd2, 32'h1234_5678);
    rd(4'd2);

    for (int n = 0; n < 4000; n++) begin
      logic [3:0]  a;
      logic [31:0] e;
      a = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'($urandom % 4);
      e = ($urandom % 3 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
      op($urandom % 4 != 0, $urandom % 2 == 1, a, $urandom, e);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule